// File: doc/BRIEF.md
# Latching Interrupt Controller

This block gathers up to 32 interrupt inputs into a set of pending-event latches. Each input is resynchronised to the block clock. It is then shaped by its own polarity and trigger settings, either level sensing or edge sensing. A qualifying event sets that source's pending bit, and the bit stays set until software writes a one to it.

An enable mask decides which pending bits appear in a masked view and reach the two interrupt outputs. A per-source routing bit sends the masked bit to either the critical or the non-critical output. Software reads the masked view, picks a source and clears its bit. For a level source it first removes the cause, because the bit sets again while the input stays active.

Register access uses a plain write strobe with an address and write data. Read data is a combinational function of the address. Register bit 31-n belongs to source n.

Top module: `irq_latch_ctrl`

## Requirements
- R1: The register offsets are: pending 0, enable 2, route 3, polarity 4, trigger 5, masked 6. Offsets 1 and 7 read as zero. `rdata_o` shows the addressed register in the same cycle, and a write takes effect at the clock edge that samples `wr_en_i`.
- R2: Input `irq_i[n]` controls register bit 31-n of every register, so source 0 is bit 31.
- R3: Writing a 1 to a pending bit clears it. A 0 leaves the bit unchanged, and a pending bit otherwise holds its value.
- R4: The masked register reads as the pending register ANDed with the enable register. Writes to offset 6 change no register.
- R5: After reset the pending, enable, route and trigger registers are zero, the polarity register is all ones and both outputs are low.
- R6: A trigger bit of 0 selects level sensing. With polarity 1 the source is active high, and with polarity 0 it is active low. While the source stays active, its pending bit sets on every clock, so a clear has no visible effect.
- R7: A trigger bit of 1 selects edge sensing. Polarity 1 latches on a rising edge and polarity 0 on a falling edge. The other edge is ignored, and the bit stays set after the input returns.
- R8: A pending bit latches whether its enable bit is 0 or 1.
- R9: When a new event and a write-one-to-clear hit the same bit on the same clock edge, the bit ends set.
- R10: `noncrit_o` is the OR of the masked bits whose route bit is 0. `crit_o` is the OR of the masked bits whose route bit is 1.
- R11: A change on `irq_i` reaches the pending register at the third rising clock edge after it: two synchroniser stages, then the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Raw interrupt inputs, index n is source n |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| noncrit_o | output | 1 | Non-critical interrupt request |
| crit_o | output | 1 | Critical interrupt request |

## Verification
The risky collision is a write-one-to-clear landing on the same edge as a fresh detected event for that bit. The bench provokes it by raising an edge-mode input and then timing the clear write two clocks later, so the write lands on the latching edge. Setting must win and the bit must read back as set. A level source cleared while still active gives the related case, and the bench judges it by reading the bit as set right after the clear. Random phases then mix input toggles with writes of every kind, and a cycle-accurate model checks every read and both outputs.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_EN    = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_ROUTE = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_POL   = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_TRIG  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 3'd6;
endpackage

// File: rtl/irq_detect.sv
module irq_detect #(
  parameter int unsigned N_SRC       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] raw_i,
  input  logic [N_SRC-1:0] trig_edge_i,
  input  logic [N_SRC-1:0] pol_high_i,
  output logic [N_SRC-1:0] event_o
);
  // stages 0..SYNC_STAGES-1 synchronise, the last one keeps history
  localparam int unsigned PIPE_D = SYNC_STAGES + 1;

  logic [PIPE_D-1:0][N_SRC-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= raw_i;
      for (int k = 1; k < PIPE_D; k++) pipe_q[k] <= pipe_q[k-1];
    end
  end

  logic [N_SRC-1:0] cur, prev;
  assign cur  = pipe_q[SYNC_STAGES-1];
  assign prev = pipe_q[SYNC_STAGES];

  for (genvar b = 0; b < N_SRC; b++) begin : g_bit
    logic lvl_hit, edge_hit;
    assign lvl_hit  = pol_high_i[b] ? cur[b] : ~cur[b];
    assign edge_hit = pol_high_i[b] ? (cur[b] & ~prev[b]) : (~cur[b] & prev[b]);
    assign event_o[b] = trig_edge_i[b] ? edge_hit : lvl_hit;
  end

  // edge-mode events never repeat on consecutive clocks with stable config
  p_edge_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(trig_edge_i) && $stable(pol_high_i)) |->
      ((event_o & $past(event_o) & trig_edge_i) == '0));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_latch_pkg::*;
#(
  parameter int unsigned N_SRC   = 32,
  parameter logic [N_SRC-1:0] POL_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  input  logic [N_SRC-1:0]  event_i,
  output logic [N_SRC-1:0]  pend_o,
  output logic [N_SRC-1:0]  en_o,
  output logic [N_SRC-1:0]  route_o,
  output logic [N_SRC-1:0]  pol_o,
  output logic [N_SRC-1:0]  trig_o
);
  logic [N_SRC-1:0] pend_q, en_q, route_q, pol_q, trig_q, clr_vec;

  assign clr_vec = (wr_en_i && addr_i == OFS_PEND) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      en_q    <= '0;
      route_q <= '0;
      pol_q   <= POL_RST;
      trig_q  <= '0;
    end else begin
      // set beats clear
      pend_q <= (pend_q & ~clr_vec) | event_i;
      if (wr_en_i) begin
        unique case (addr_i)
          OFS_EN:    en_q    <= wdata_i;
          OFS_ROUTE: route_q <= wdata_i;
          OFS_POL:   pol_q   <= wdata_i;
          OFS_TRIG:  trig_q  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign pend_o  = pend_q;
  assign en_o    = en_q;
  assign route_o = route_q;
  assign pol_o   = pol_q;
  assign trig_o  = trig_q;

  p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_PEND) |=>
      ((pend_q & $past(wdata_i) & ~$past(event_i)) == '0));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == OFS_PEND) |=> (($past(pend_q) & ~pend_q) == '0));

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i != '0) |=> (($past(event_i) & ~pend_q) == '0));

  p_mask_ro_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_MASK) |=>
      ($stable(en_q) && $stable(route_q) && $stable(pol_q) && $stable(trig_q)));
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] route_i,
  output logic [N_SRC-1:0] masked_o,
  output logic             noncrit_o,
  output logic             crit_o
);
  logic [N_SRC-1:0] to_nc, to_cr;

  for (genvar b = 0; b < N_SRC; b++) begin : g_bit
    assign masked_o[b] = pend_i[b] & en_i[b];
    assign to_nc[b]    = masked_o[b] & ~route_i[b];
    assign to_cr[b]    = masked_o[b] & route_i[b];
  end

  assign noncrit_o = |to_nc;
  assign crit_o    = |to_cr;

  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i & en_i) == '0) |-> !(noncrit_o || crit_o));

  p_crit_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_o |-> ((pend_i & en_i & route_i) != '0));
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int unsigned N_SRC       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic              noncrit_o,
  output logic              crit_o
);
  logic [N_SRC-1:0] raw_reg, evt, pend, en, route, pol, trig, masked;

  // source n lives at register bit N_SRC-1-n
  for (genvar n = 0; n < N_SRC; n++) begin : g_map
    assign raw_reg[N_SRC-1-n] = irq_i[n];
  end

  irq_detect #(.N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES)) i_detect (
    .clk_i, .rst_ni,
    .raw_i(raw_reg), .trig_edge_i(trig), .pol_high_i(pol), .event_o(evt)
  );

  irq_regs #(.N_SRC(N_SRC)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .event_i(evt), .pend_o(pend), .en_o(en), .route_o(route),
    .pol_o(pol), .trig_o(trig)
  );

  irq_route #(.N_SRC(N_SRC)) i_route (
    .clk_i, .rst_ni, .pend_i(pend), .en_i(en), .route_i(route),
    .masked_o(masked), .noncrit_o, .crit_o
  );

  always_comb begin
    unique case (addr_i)
      OFS_PEND:  rdata_o = pend;
      OFS_EN:    rdata_o = en;
      OFS_ROUTE: rdata_o = route;
      OFS_POL:   rdata_o = pol;
      OFS_TRIG:  rdata_o = trig;
      OFS_MASK:  rdata_o = masked;
      default:   rdata_o = '0;
    endcase
  end

  p_mask_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_MASK) |-> (rdata_o == (pend & en)));

  p_hole_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd1 || addr_i == 3'd7) |-> (rdata_o == '0));
endmodule

// File: tb/test_irq_latch_ctrl.sv
module test_irq_latch_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        nc, cr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_latch_ctrl i_irq_latch_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_en_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .noncrit_o(nc), .crit_o(cr)
  );

  // reference model built from the requirements
  logic [31:0] m_p1, m_p2, m_p3, m_sr, m_er, m_cr, m_pr, m_tr;

  function automatic logic [31:0] rev(input logic [31:0] v);
    for (int i = 0; i < 32; i++) rev[31-i] = v[i];
  endfunction

  function automatic logic [31:0] m_evt();
    logic [31:0] e;
    for (int i = 0; i < 32; i++)
      if (m_tr[i]) e[i] = m_pr[i] ? (m_p2[i] & ~m_p3[i]) : (~m_p2[i] & m_p3[i]);
      else         e[i] = m_pr[i] ? m_p2[i] : ~m_p2[i];
    return e;
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_sr;
      3'd2: return m_er;
      3'd3: return m_cr;
      3'd4: return m_pr;
      3'd5: return m_tr;
      3'd6: return m_sr & m_er;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p1 <= '0; m_p2 <= '0; m_p3 <= '0; m_sr <= '0;
      m_er <= '0; m_cr <= '0; m_pr <= '1; m_tr <= '0;
    end else begin
      m_sr <= (m_sr & ~((we && addr == 3'd0) ? wdata : 32'd0)) | m_evt();
      m_p3 <= m_p2; m_p2 <= m_p1; m_p1 <= rev(irq);
      if (we) case (addr)
        3'd2: m_er <= wdata;
        3'd3: m_cr <= wdata;
        3'd4: m_pr <= wdata;
        3'd5: m_tr <= wdata;
        default: ;
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick(1);
    we = 1'b0;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    tick(2);
    rst_n = 1'b1;
    tick(1);
    // R5 reset state
    rd_chk("R5 pending", 3'd0, 32'h0);
    rd_chk("R5 enable", 3'd2, 32'h0);
    rd_chk("R5 route", 3'd3, 32'h0);
    rd_chk("R5 trigger", 3'd5, 32'h0);
    rd_chk("R5 polarity", 3'd4, 32'hffff_ffff);
    chk("R5 outputs", {30'd0, nc, cr}, 32'h0);

    // R2 / R11 / R10: source 0 lands at bit 31 after three edges
    wr(3'd2, 32'hffff_ffff);
    irq[0] = 1'b1;
    tick(2);
    rd_chk("R11 not yet latched", 3'd0, 32'h0);
    tick(1);
    rd_chk("R2 R11 source0 bit31", 3'd0, 32'h8000_0000);
    chk("R10 noncrit", {30'd0, nc, cr}, 32'h2);

    // R6: clear while level still active re-latches
    wr(3'd0, 32'h8000_0000);
    rd_chk("R6 relatch", 3'd0, 32'h8000_0000);

    // R3: zero writes leave it, one writes clear it
    irq[0] = 1'b0;
    tick(3);
    wr(3'd0, 32'h0);
    rd_chk("R3 write zero", 3'd0, 32'h8000_0000);
    wr(3'd0, 32'h8000_0000);
    rd_chk("R3 write one", 3'd0, 32'h0);
    chk("R3 outputs low", {30'd0, nc, cr}, 32'h0);

    // R8: latch while disabled
    wr(3'd2, 32'h0);
    irq[3] = 1'b1;
    tick(3);
    rd_chk("R8 pending", 3'd0, 32'h1000_0000);
    rd_chk("R8 masked", 3'd6, 32'h0);
    chk("R8 outputs", {30'd0, nc, cr}, 32'h0);
    irq[3] = 1'b0;
    tick(3);
    wr(3'd0, 32'hffff_ffff);
    wr(3'd2, 32'hffff_ffff);

    // R7: rising edge on source 5 (bit 26)
    wr(3'd5, 32'h0400_0000);
    irq[5] = 1'b1;
    tick(3);
    rd_chk("R7 rising latch", 3'd0, 32'h0400_0000);
    irq[5] = 1'b0;
    tick(3);
    rd_chk("R7 stays set", 3'd0, 32'h0400_0000);
    wr(3'd0, 32'h0400_0000);
    rd_chk("R7 cleared", 3'd0, 32'h0);
    // falling edge
    wr(3'd4, 32'hfbff_ffff);
    tick(1);
    irq[5] = 1'b1;
    tick(3);
    rd_chk("R7 rise ignored when falling", 3'd0, 32'h0);
    irq[5] = 1'b0;
    tick(3);
    rd_chk("R7 falling latch", 3'd0, 32'h0400_0000);
    rd_chk("R1 polarity readback", 3'd4, 32'hfbff_ffff);
    rd_chk("R1 trigger readback", 3'd5, 32'h0400_0000);

    // R9: new edge and clear on the same edge
    wr(3'd4, 32'hffff_ffff);
    irq[5] = 1'b1;
    tick(2);
    we = 1'b1; addr = 3'd0; wdata = 32'h0400_0000;
    tick(1);
    we = 1'b0;
    rd_chk("R9 set wins", 3'd0, 32'h0400_0000);
    irq[5] = 1'b0;
    tick(3);
    wr(3'd0, 32'hffff_ffff);
    wr(3'd5, 32'h0);

    // R10 critical routing on source 7 (bit 24)
    wr(3'd3, 32'h0100_0000);
    irq[7] = 1'b1;
    tick(3);
    chk("R10 critical", {30'd0, nc, cr}, 32'h1);
    rd_chk("R4 masked", 3'd6, 32'h0100_0000);
    wr(3'd6, 32'h0);
    rd_chk("R4 write ignored en", 3'd2, 32'hffff_ffff);
    rd_chk("R4 write ignored route", 3'd3, 32'h0100_0000);
    rd_chk("R4 write ignored pending", 3'd0, 32'h0100_0000);
    rd_chk("R1 hole 1", 3'd1, 32'h0);
    rd_chk("R1 hole 7", 3'd7, 32'h0);
    irq[7] = 1'b0;
    tick(3);
    wr(3'd0, 32'hffff_ffff);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      chk("R1 R4 R6 R7 random read", rdata, exp_read(addr));
      chk("R10 random outputs", {30'd0, nc, cr},
          {30'd0, |(m_sr & m_er & ~m_cr), |(m_sr & m_er & m_cr)});
      for (int b = 0; b < 32; b++)
        if ($urandom_range(0, 15) == 0) irq[b] = ~irq[b];
      we    = ($urandom_range(0, 3) == 0);
      addr  = 3'($urandom_range(0, 7));
      wdata = $urandom();
      tick(1);
    end
    we = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule